// File: doc/BRIEF.md
# Dual-Bank Flash Reset Sequencer

This controller sits on the host side of a two-bank parallel flash. It produces the reset that such a part needs, and the part has no dedicated reset pin. A bank is reset by driving its bank-enable line, the shared write-enable line and the shared output-enable line low together. The sequencer holds them low for longer than the minimum reset time and then releases all three on one clock edge. It then waits out the recovery time before the bank may be read again. The banks cannot be reset together, so the sequencer never drives two bank enables low in the same cycle.

When the synchronous reset is released, the sequencer resets bank 0 and then bank 1 without any request. It raises `ready` only after both banks are done. After that, a one-cycle request strobe with a bank index forces a reset of the selected bank. The host must treat any operation that was pending on that bank as cancelled, because the bank discards it. A request that arrives while a sequence is running is dropped. The hold and recovery times are given in nanoseconds and turned into cycle counts at elaboration. Both counts are rounded up, and one margin cycle is added to the hold count.

Top module: `flash_bank_rst_seq`

## Requirements
- R1: While `rst` is high, from the first clock edge on, `bank_en_n` is all ones, `wr_en_n` and `out_en_n` are 1, and `busy` and `ready` are 0.
- R2: Each reset pulse keeps the control lines low for exactly HOLD_CYC cycles. HOLD_CYC = ceil(HOLD_NS/CLK_NS) + HOLD_MARGIN, which is 501 with the defaults.
- R3: During a pulse, exactly one bit of `bank_en_n` is low, and that bit's index is the bank being reset. `wr_en_n` and `out_en_n` are low in exactly the same cycles as that bit.
- R4: The bank enable, `wr_en_n` and `out_en_n` all return high on the same clock edge.
- R5: Two bank enables are never low in the same cycle.
- R6: After the lines return high, `busy` stays high for exactly REC_CYC = ceil(RECOVER_NS/CLK_NS) cycles, which is 75 with the defaults.
- R7: `busy` rises on the edge where the lines fall and stays high for the whole low pulse.
- R8: After `rst` is released, the sequencer resets bank 0 and then bank 1 with no request. `ready` stays 0 until bank 1 has finished its recovery, and then becomes 1.
- R9: A request strobe that arrives while `busy` is high is dropped. No extra pulse follows that sequence.
- R10: A request that is high on a clock edge while the block is idle with initialisation complete starts a pulse on the bank given by `rst_bank` (0 or 1). A request held during initialisation is served only after both initial resets.
- R11: `ready` is 1 only when the block is idle and initialisation is complete. It is 0 throughout any pulse and any recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts power-up initialisation when released |
| rst_req | input | 1 | Request to reset one bank, sampled while idle |
| rst_bank | input | BANK_W | Index of the bank to reset with the request |
| bank_en_n | output | NUM_BANKS | Active-low bank enables, registered |
| wr_en_n | output | 1 | Active-low write enable shared by the banks, registered |
| out_en_n | output | 1 | Active-low output enable shared by the banks, registered |
| busy | output | 1 | High from the start of a pulse to the end of its recovery |
| ready | output | 1 | Initialisation done and no sequence running |

## Verification
Two functions can meet in one cycle: the automatic power-up chain and a host request. The bench holds `rst_req` high for bank 1 from before reset is released. It then judges two things: the bank 0 and bank 1 initial pulses must come first, and the request must be served only once those are finished. The request is dropped as soon as the forced pulse is seen. The second overlap is a strobe fired in the middle of a running pulse. It must leave no trace, so the bench watches the lines and `busy` for a window after recovery and expects them quiet.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ASSERT  = 3'd1,
    ST_HOLD    = 3'd2,
    ST_RELEASE = 3'd3,
    ST_RECOVER = 3'd4,
    ST_DONE    = 3'd5
  } seq_state_t;

  // Cycles needed to cover a span in ns, rounded up.
  function automatic int ns_to_cycles(input int span_ns, input int clk_ns);
    return (span_ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/frs_interval_timer.sv
module frs_interval_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/frs_seq_fsm.sv
module frs_seq_fsm
  import flash_rst_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1,
  parameter int CNT_W     = 9,
  parameter int HOLD_CYC  = 501,
  parameter int REC_CYC   = 75
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              t_zero,
  output logic              t_load,
  output logic [CNT_W-1:0]  t_val,
  output seq_state_t        state_nxt,
  output logic [BANK_W-1:0] bank_nxt,
  output logic              init_done_nxt
);

  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);
  localparam logic [CNT_W-1:0]  HOLD_LOAD = CNT_W'(HOLD_CYC - 2);
  localparam logic [CNT_W-1:0]  REC_LOAD  = CNT_W'(REC_CYC - 2);

  seq_state_t        state_q;
  logic [BANK_W-1:0] bank_q;
  logic              init_done_q;

  always_comb begin
    state_nxt     = state_q;
    bank_nxt      = bank_q;
    init_done_nxt = init_done_q;
    t_load        = 1'b0;
    t_val         = '0;
    case (state_q)
      ST_IDLE: begin
        if (!init_done_q) begin
          bank_nxt  = '0;
          state_nxt = ST_ASSERT;
        end else if (req) begin
          bank_nxt  = req_bank;
          state_nxt = ST_ASSERT;
        end
      end
      ST_ASSERT: begin
        t_load    = 1'b1;
        t_val     = HOLD_LOAD;
        state_nxt = ST_HOLD;
      end
      ST_HOLD: begin
        if (t_zero) state_nxt = ST_RELEASE;
      end
      ST_RELEASE: begin
        t_load    = 1'b1;
        t_val     = REC_LOAD;
        state_nxt = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (t_zero) state_nxt = ST_DONE;
      end
      ST_DONE: begin
        if (!init_done_q && bank_q != LAST_BANK) begin
          bank_nxt  = bank_q + 1'b1;
          state_nxt = ST_ASSERT;
        end else begin
          init_done_nxt = 1'b1;
          state_nxt     = ST_IDLE;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      bank_q      <= '0;
      init_done_q <= 1'b0;
    end else begin
      state_q     <= state_nxt;
      bank_q      <= bank_nxt;
      init_done_q <= init_done_nxt;
    end
  end

endmodule

// File: rtl/frs_pin_driver.sv
module frs_pin_driver
  import flash_rst_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  seq_state_t           state_nxt,
  input  logic [BANK_W-1:0]    bank_nxt,
  input  logic                 init_done_nxt,
  output logic [NUM_BANKS-1:0] bank_en_n,
  output logic                 wr_en_n,
  output logic                 out_en_n,
  output logic                 busy,
  output logic                 ready
);

  logic drive_low;
  logic seq_active;

  assign drive_low  = (state_nxt == ST_ASSERT) || (state_nxt == ST_HOLD);
  assign seq_active = drive_low || (state_nxt == ST_RELEASE) ||
                      (state_nxt == ST_RECOVER);

  // All lines come from flops fed by one decode, so they switch together.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_n  <= 1'b1;
      out_en_n <= 1'b1;
      busy     <= 1'b0;
      ready    <= 1'b0;
    end else begin
      wr_en_n  <= !drive_low;
      out_en_n <= !drive_low;
      busy     <= seq_active;
      ready    <= init_done_nxt && (state_nxt == ST_IDLE);
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank_en
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_en_n[g] <= 1'b1;
      end else begin
        bank_en_n[g] <= !(drive_low && (bank_nxt == BANK_W'(g)));
      end
    end
  end

endmodule

// File: rtl/flash_bank_rst_seq.sv
module flash_bank_rst_seq
  import flash_rst_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int HOLD_NS     = 5000,
  parameter int RECOVER_NS  = 750,
  parameter int HOLD_MARGIN = 1,
  parameter int NUM_BANKS   = 2,
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rst_req,
  input  logic [BANK_W-1:0]    rst_bank,
  output logic [NUM_BANKS-1:0] bank_en_n,
  output logic                 wr_en_n,
  output logic                 out_en_n,
  output logic                 busy,
  output logic                 ready
);

  localparam int HOLD_RAW = ns_to_cycles(HOLD_NS, CLK_NS) + HOLD_MARGIN;
  localparam int REC_RAW  = ns_to_cycles(RECOVER_NS, CLK_NS);
  localparam int HOLD_CYC = (HOLD_RAW < 2) ? 2 : HOLD_RAW;
  localparam int REC_CYC  = (REC_RAW < 2) ? 2 : REC_RAW;
  localparam int MAX_CYC  = (HOLD_CYC > REC_CYC) ? HOLD_CYC : REC_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic              t_load;
  logic              t_zero;
  logic [CNT_W-1:0]  t_val;
  seq_state_t        state_nxt;
  logic [BANK_W-1:0] bank_nxt;
  logic              init_done_nxt;

  frs_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  frs_seq_fsm #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .CNT_W     (CNT_W),
    .HOLD_CYC  (HOLD_CYC),
    .REC_CYC   (REC_CYC)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req           (rst_req),
    .req_bank      (rst_bank),
    .t_zero        (t_zero),
    .t_load        (t_load),
    .t_val         (t_val),
    .state_nxt     (state_nxt),
    .bank_nxt      (bank_nxt),
    .init_done_nxt (init_done_nxt)
  );

  frs_pin_driver #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_drv (
    .clk           (clk),
    .rst           (rst),
    .state_nxt     (state_nxt),
    .bank_nxt      (bank_nxt),
    .init_done_nxt (init_done_nxt),
    .bank_en_n     (bank_en_n),
    .wr_en_n       (wr_en_n),
    .out_en_n      (out_en_n),
    .busy          (busy),
    .ready         (ready)
  );

endmodule

// File: rtl/flash_bank_rst_seq_chk.sv
module flash_bank_rst_seq_chk #(
  parameter int NUM_BANKS = 2,
  parameter int HOLD_CYC  = 501,
  parameter int REC_CYC   = 75
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_BANKS-1:0] bank_en_n,
  input logic                 wr_en_n,
  input logic                 out_en_n,
  input logic                 busy,
  input logic                 ready
);

  int unsigned low_cnt;
  int unsigned rec_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= 0;
      rec_cnt <= 0;
    end else begin
      low_cnt <= wr_en_n ? 0 : low_cnt + 1;
      rec_cnt <= (busy && wr_en_n) ? rec_cnt + 1 : 0;
    end
  end

  assert_low_width_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en_n) |-> low_cnt == HOLD_CYC);

  assert_one_bank_with_strobes_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_n == out_en_n) && (!wr_en_n == ($countones(~bank_en_n) == 1)));

  assert_joint_release_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en_n) |-> (out_en_n && (&bank_en_n)));

  assert_no_dual_bank_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(~bank_en_n) <= 1);

  assert_recovery_gap_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rec_cnt == REC_CYC);

  assert_busy_covers_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en_n |-> busy);

  assert_ready_only_idle_R11: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!busy && wr_en_n && (&bank_en_n)));

endmodule

bind flash_bank_rst_seq flash_bank_rst_seq_chk #(
  .NUM_BANKS (NUM_BANKS),
  .HOLD_CYC  (HOLD_CYC),
  .REC_CYC   (REC_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bank_en_n (bank_en_n),
  .wr_en_n   (wr_en_n),
  .out_en_n  (out_en_n),
  .busy      (busy),
  .ready     (ready)
);

// File: tb/test_flash_bank_rst_seq.sv
module test_flash_bank_rst_seq;

  localparam int CLK_NS     = 10;
  localparam int HOLD_NS    = 5000;
  localparam int RECOVER_NS = 750;
  localparam int EXP_HOLD   = HOLD_NS / CLK_NS + ((HOLD_NS % CLK_NS) != 0 ? 1 : 0) + 1;
  localparam int EXP_REC    = RECOVER_NS / CLK_NS + ((RECOVER_NS % CLK_NS) != 0 ? 1 : 0);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_req = 1'b0;
  logic [0:0] rst_bank = 1'b0;
  logic [1:0] bank_en_n;
  logic       wr_en_n;
  logic       out_en_n;
  logic       busy;
  logic       ready;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flash_bank_rst_seq i_flash_bank_rst_seq (
    .clk       (clk),
    .rst       (rst),
    .rst_req   (rst_req),
    .rst_bank  (rst_bank),
    .bank_en_n (bank_en_n),
    .wr_en_n   (wr_en_n),
    .out_en_n  (out_en_n),
    .busy      (busy),
    .ready     (ready)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic fire_req(input int bank);
    @(negedge clk);
    rst_req  = 1'b1;
    rst_bank = 1'(bank);
    @(negedge clk);
    rst_req  = 1'b0;
  endtask

  // Measures one full pulse and its recovery; returns at the first sample with busy low.
  task automatic run_pulse(input int bank, input string start_rq);
    logic [1:0] exp_en;
    int waitc = 0;
    int low = 0;
    int gap = 0;
    int bad_both = 0;
    int bad_sync = 0;
    int bad_busy = 0;
    int bad_hi = 0;
    int bad_rdy = 0;
    exp_en = ~(2'b01 << bank);
    while (bank_en_n == 2'b11 && waitc < 200) begin
      @(negedge clk);
      waitc++;
    end
    check(bank_en_n != 2'b11, start_rq, "pulse start", int'(bank_en_n), int'(exp_en));
    check(bank_en_n == exp_en, "R3", "selected bank low", int'(bank_en_n), int'(exp_en));
    check(!wr_en_n && !out_en_n, "R3", "strobes low with bank", int'({wr_en_n, out_en_n}), 0);
    check(busy == 1'b1, "R7", "busy at pulse start", int'(busy), 1);
    while (bank_en_n != 2'b11 && low < EXP_HOLD + 20) begin
      if (bank_en_n == 2'b00) bad_both++;
      if (bank_en_n != exp_en || wr_en_n || out_en_n) bad_sync++;
      if (!busy) bad_busy++;
      low++;
      @(negedge clk);
    end
    check(low == EXP_HOLD, "R2", "low pulse cycles", low, EXP_HOLD);
    check(bad_both == 0, "R5", "cycles with both banks low", bad_both, 0);
    check(bad_sync == 0, "R3", "cycles with lines out of step", bad_sync, 0);
    check(bad_busy == 0, "R7", "cycles busy low during pulse", bad_busy, 0);
    check(wr_en_n && out_en_n, "R4", "strobes released with bank", int'({wr_en_n, out_en_n}), 3);
    while (busy && gap < EXP_REC + 20) begin
      if (bank_en_n != 2'b11 || !wr_en_n || !out_en_n) bad_hi++;
      if (ready) bad_rdy++;
      gap++;
      @(negedge clk);
    end
    check(gap == EXP_REC, "R6", "recovery cycles", gap, EXP_REC);
    check(bad_hi == 0, "R4", "lines low during recovery", bad_hi, 0);
    check(bad_rdy == 0, "R11", "ready during recovery", bad_rdy, 0);
  endtask

  task automatic quiet_window(input int cycles, input string rq);
    int noise = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (bank_en_n != 2'b11 || !wr_en_n || busy) noise++;
    end
    check(noise == 0, rq, "activity in quiet window", noise, 0);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(bank_en_n == 2'b11, "R1", "bank enables in reset", int'(bank_en_n), 3);
    check(wr_en_n && out_en_n, "R1", "strobes in reset", int'({wr_en_n, out_en_n}), 3);
    check(!busy && !ready, "R1", "flags in reset", int'({busy, ready}), 0);
  endtask

  task automatic t_powerup();
    rst = 1'b0;
    run_pulse(0, "R8");
    check(ready == 1'b0, "R8", "ready after bank 0 only", int'(ready), 0);
    run_pulse(1, "R8");
    check(ready == 1'b0, "R11", "ready in final recovery sample", int'(ready), 0);
    @(negedge clk);
    check(ready == 1'b1 && !busy, "R8", "ready after both banks", int'({ready, busy}), 2);
    quiet_window(30, "R10");
  endtask

  task automatic t_forced(input int bank);
    fire_req(bank);
    run_pulse(bank, "R10");
    @(negedge clk);
    check(ready == 1'b1, "R11", "ready after forced reset", int'(ready), 1);
  endtask

  task automatic t_req_while_busy();
    fire_req(0);
    fork
      run_pulse(0, "R10");
      begin
        repeat (100) @(negedge clk);
        rst_req  = 1'b1;
        rst_bank = 1'b1;
        @(negedge clk);
        rst_req  = 1'b0;
      end
    join
    quiet_window(40, "R9");
    check(ready == 1'b1, "R9", "ready after dropped request", int'(ready), 1);
  endtask

  task automatic t_req_during_init();
    int waitc = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst_req  = 1'b1;
    rst_bank = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    run_pulse(0, "R8");
    run_pulse(1, "R10");
    while (bank_en_n == 2'b11 && waitc < 10) begin
      @(negedge clk);
      waitc++;
    end
    rst_req = 1'b0;
    check(bank_en_n == 2'b01, "R10", "held request served after init", int'(bank_en_n), 1);
    run_pulse(1, "R10");
    quiet_window(20, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_powerup();
    t_forced(1);
    t_forced(0);
    t_req_while_busy();
    t_req_during_init();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule